// File: doc/BRIEF.md
# H-Bridge Gate Command and Fault Latch

This block is the digital control for one H-bridge. It takes two polarity inputs, one per leg, plus an active-high disable input and an active-high enable input. From these it produces the on-commands for the high-side and low-side switch of each leg. It also drives an active-low status flag and a sleep indication.

Fault indications arrive as synchronous single-bit inputs: undervoltage, short-circuit, overtemperature, and a "cooled past hysteresis" indication. Short-circuit and overtemperature are latched and shut the bridge off. A latch is released only by an edge on the control pins. Undervoltage and current-limit requests switch the bridge off only while they are present.

Every output is registered, so each output follows its inputs one clock later. Each leg has a dead-time stage. When a leg's switch turns off, the stage holds that leg fully off for a parameterised number of cycles before the opposite switch, or the same one, may turn on.

Top module: `hbridge_ctrl`

## Requirements
- R1: With enIn=1, disIn=0, no fault, no undervoltage and no current-limit request, leg i drives hiOn[i]=1 when polIn[i]=1 and loOn[i]=1 when polIn[i]=0, once the dead time has expired. This covers forward (polIn=01), reverse (10), low freewheel (00) and high freewheel (11).
- R2: While enIn=1 and disIn=1, all four switch commands are 0 and statusN is 0 one cycle later.
- R3: While enIn=0, all switch commands are 0, sleepOut is 1 and statusN is 1 one cycle later. No fault is latched while enIn=0.
- R4: A short-circuit or overtemperature input seen while enIn=1 latches. Until it is cleared, all switch commands stay 0 and statusN stays 0, whatever the polarity inputs do.
- R5: A latched fault is cleared by a 1-to-0 edge of disIn or a 0-to-1 edge of enIn, and statusN returns to 1. If a fault input is active in the same cycle, it wins over the clear.
- R6: A latched overtemperature is cleared by an enIn rising edge as long as otFault is 0. A disIn falling edge clears it only if otCool=1 in that cycle.
- R7: Undervoltage with enIn=1 switches all legs off and drives statusN to 0 one cycle later. Both recover on their own once uvFault drops, with no latch.
- R8: A fault input turns every switch command off at the next clock edge (a latency of 1 cycle).
- R9: hiOn[i] and loOn[i] are never both 1. After a leg switches off, it stays fully off for at least DEAD_CYC cycles before either of its switches turns on.
- R10: climReq=1 turns all switch commands off one cycle later and leaves statusN unchanged.
- R11: Reset leaves all switches off, no fault latched, statusN=1 and sleepOut=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enIn | input | 1 | Enable (0 = sleep) |
| disIn | input | 1 | Active-high disable |
| polIn | input | LEGS | Polarity per leg (1 = high side, 0 = low side) |
| uvFault | input | 1 | Undervoltage indication |
| otFault | input | 1 | Temperature above shutdown threshold |
| otCool | input | 1 | Temperature below threshold minus hysteresis |
| scFault | input | 1 | Short-circuit indication |
| climReq | input | 1 | Current-limit off request |
| hiOn | output | LEGS | High-side switch commands |
| loOn | output | LEGS | Low-side switch commands |
| statusN | output | 1 | Active-low status flag |
| sleepOut | output | 1 | Sleep indication |

## Verification
The hardest case to reach is a latched overtemperature that survives a disable toggle because the hysteresis condition is not met. To get there, the stimulus pulses otFault and then drops it while holding otCool low. It then toggles disIn and checks that statusN stays low. Finally it raises otCool and toggles disIn again, expecting the clear. A second pass clears the same latch through an enable toggle with otCool still low. After that, a randomised phase with rare fault pulses is compared cycle by cycle against a behavioural model.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } legState_e;

  typedef struct packed {
    logic driveOk;
    logic flagLow;
    logic sleep;
  } ctrlStrobe_t;
endpackage

// File: rtl/hbridge_fault_ctrl.sv
module hbridge_fault_ctrl
  import hbridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enIn,
  input  logic        disIn,
  input  logic        uvFault,
  input  logic        otFault,
  input  logic        otCool,
  input  logic        scFault,
  input  logic        climReq,
  output ctrlStrobe_t strobe
);
  logic enPrev, disPrev;
  logic scLatch, otLatch;
  logic scNext, otNext;
  logic clrByEn, clrByDis;

  always_comb begin
    clrByEn  = enIn && !enPrev;
    clrByDis = !disIn && disPrev;
  end

  // set wins over clear; faults are only sensed while enabled
  always_comb begin
    if (enIn && scFault)          scNext = 1'b1;
    else if (clrByEn || clrByDis) scNext = 1'b0;
    else                          scNext = scLatch;

    if (enIn && otFault)          otNext = 1'b1;
    else if (clrByEn)             otNext = 1'b0;
    else if (clrByDis && otCool)  otNext = 1'b0;
    else                          otNext = otLatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      disPrev <= 1'b0;
      scLatch <= 1'b0;
      otLatch <= 1'b0;
    end else begin
      enPrev  <= enIn;
      disPrev <= disIn;
      scLatch <= scNext;
      otLatch <= otNext;
    end
  end

  always_comb begin
    strobe.sleep   = !enIn;
    strobe.flagLow = enIn && (disIn || uvFault || scNext || otNext);
    strobe.driveOk = enIn && !disIn && !uvFault && !climReq && !scNext && !otNext;
  end
endmodule

// File: rtl/hbridge_leg.sv
module hbridge_leg
  import hbridge_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic driveOk,
  input  logic polarity,
  output logic hiOn,
  output logic loOn
);
  localparam int CW = $clog2(DEAD_CYC + 2);

  legState_e      state, target;
  logic [CW-1:0]  deadCnt;

  always_comb begin
    if (!driveOk)      target = LEG_OFF;
    else if (polarity) target = LEG_HIGH;
    else               target = LEG_LOW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= LEG_OFF;
      deadCnt <= '0;
    end else begin
      case (state)
        LEG_OFF: begin
          if (deadCnt != '0)          deadCnt <= deadCnt - 1'b1;
          else if (target != LEG_OFF) state   <= target;
        end
        default: begin
          if (target != state) begin
            state   <= LEG_OFF;
            deadCnt <= CW'(DEAD_CYC);
          end
        end
      endcase
    end
  end

  assign hiOn = (state == LEG_HIGH);
  assign loOn = (state == LEG_LOW);
endmodule

// File: rtl/hbridge_datapath.sv
module hbridge_datapath
  import hbridge_pkg::*;
#(
  parameter int LEGS     = 2,
  parameter int DEAD_CYC = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [LEGS-1:0] polIn,
  output logic [LEGS-1:0] hiOn,
  output logic [LEGS-1:0] loOn,
  output logic            statusN,
  output logic            sleepOut
);
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hbridge_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk      (clk),
      .rstN     (rstN),
      .driveOk  (strobe.driveOk),
      .polarity (polIn[g]),
      .hiOn     (hiOn[g]),
      .loOn     (loOn[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusN  <= 1'b1;
      sleepOut <= 1'b1;
    end else begin
      statusN  <= !strobe.flagLow;
      sleepOut <= strobe.sleep;
    end
  end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hbridge_pkg::*;
#(
  parameter int LEGS     = 2,
  parameter int DEAD_CYC = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enIn,
  input  logic            disIn,
  input  logic [LEGS-1:0] polIn,
  input  logic            uvFault,
  input  logic            otFault,
  input  logic            otCool,
  input  logic            scFault,
  input  logic            climReq,
  output logic [LEGS-1:0] hiOn,
  output logic [LEGS-1:0] loOn,
  output logic            statusN,
  output logic            sleepOut
);
  ctrlStrobe_t strobe;

  hbridge_fault_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enIn    (enIn),
    .disIn   (disIn),
    .uvFault (uvFault),
    .otFault (otFault),
    .otCool  (otCool),
    .scFault (scFault),
    .climReq (climReq),
    .strobe  (strobe)
  );

  hbridge_datapath #(.LEGS(LEGS), .DEAD_CYC(DEAD_CYC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .polIn    (polIn),
    .hiOn     (hiOn),
    .loOn     (loOn),
    .statusN  (statusN),
    .sleepOut (sleepOut)
  );
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk #(
  parameter int LEGS     = 2,
  parameter int DEAD_CYC = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            enIn,
  input logic            disIn,
  input logic            uvFault,
  input logic            otFault,
  input logic            scFault,
  input logic            climReq,
  input logic [LEGS-1:0] hiOn,
  input logic [LEGS-1:0] loOn,
  input logic            statusN,
  input logic            sleepOut
);
  localparam int CW = $clog2(DEAD_CYC + 2);

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rstN)
    (hiOn & loOn) == '0); // R9

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    enIn && (scFault || otFault) |=> (hiOn == '0) && (loOn == '0) && !statusN); // R8

  AST_SLEEP_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> sleepOut && statusN && (hiOn == '0) && (loOn == '0)); // R3

  AST_DISABLE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    enIn && disIn |=> !statusN && (hiOn == '0) && (loOn == '0)); // R2

  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    enIn && uvFault |=> !statusN && (hiOn == '0) && (loOn == '0)); // R7

  AST_CLIM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    climReq |=> (hiOn == '0) && (loOn == '0)); // R10

  for (genvar g = 0; g < LEGS; g++) begin : g_dead
    logic [CW-1:0] offCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) offCnt <= CW'(DEAD_CYC);
      else if (hiOn[g] || loOn[g]) offCnt <= '0;
      else if (offCnt < CW'(DEAD_CYC)) offCnt <= offCnt + 1'b1;
    end

    AST_DEAD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      $rose(hiOn[g]) |-> offCnt >= CW'(DEAD_CYC)); // R9
    AST_DEAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
      $rose(loOn[g]) |-> offCnt >= CW'(DEAD_CYC)); // R9
  end
endmodule

bind hbridge_ctrl hbridge_ctrl_chk #(.LEGS(LEGS), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enIn     (enIn),
  .disIn    (disIn),
  .uvFault  (uvFault),
  .otFault  (otFault),
  .scFault  (scFault),
  .climReq  (climReq),
  .hiOn     (hiOn),
  .loOn     (loOn),
  .statusN  (statusN),
  .sleepOut (sleepOut)
);

// File: tb/hbridge_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_ctrl_test;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 0, disIn = 0, uvFault = 0, otFault = 0, otCool = 0, scFault = 0, climReq = 0;
  logic [1:0] polIn = 2'b00;
  logic [1:0] hiOn, loOn;
  logic statusN, sleepOut;

  int vecCnt = 0;
  int failCnt = 0;

  // reference state
  bit mSc, mOt, mEnP, mDisP, mFlagN, mSleep;
  int mCur[2];   // 0 off, 1 high, 2 low
  int mCnt[2];

  always #2.5 clk = ~clk;

  hbridge_ctrl #(.LEGS(2), .DEAD_CYC(DEAD)) uut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .disIn(disIn), .polIn(polIn),
    .uvFault(uvFault), .otFault(otFault), .otCool(otCool), .scFault(scFault),
    .climReq(climReq), .hiOn(hiOn), .loOn(loOn), .statusN(statusN), .sleepOut(sleepOut)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mSc = 0; mOt = 0; mEnP = 0; mDisP = 0; mFlagN = 1; mSleep = 1;
    for (int i = 0; i < 2; i++) begin mCur[i] = 0; mCnt[i] = 0; end
  endtask

  task automatic modelClock();
    bit clrE, clrD, nSc, nOt, drive;
    int tgt;
    clrE = enIn && !mEnP;
    clrD = !disIn && mDisP;
    if (enIn && scFault) nSc = 1;
    else if (clrE || clrD) nSc = 0;
    else nSc = mSc;
    if (enIn && otFault) nOt = 1;
    else if (clrE) nOt = 0;
    else if (clrD && otCool) nOt = 0;
    else nOt = mOt;
    drive = enIn && !disIn && !uvFault && !climReq && !nSc && !nOt;
    mFlagN = !(enIn && (disIn || uvFault || nSc || nOt));
    mSleep = !enIn;
    for (int i = 0; i < 2; i++) begin
      tgt = drive ? (polIn[i] ? 1 : 2) : 0;
      if (mCur[i] == 0) begin
        if (mCnt[i] > 0) mCnt[i]--;
        else if (tgt != 0) mCur[i] = tgt;
      end else if (tgt != mCur[i]) begin
        mCur[i] = 0;
        mCnt[i] = DEAD;
      end
    end
    mSc = nSc; mOt = nOt; mEnP = enIn; mDisP = disIn;
  endtask

  function automatic logic [7:0] expVec();
    logic [1:0] h, l;
    for (int i = 0; i < 2; i++) begin
      h[i] = (mCur[i] == 1);
      l[i] = (mCur[i] == 2);
    end
    return {2'b00, h, l, mFlagN, mSleep};
  endfunction

  task automatic step(string tag);
    @(posedge clk);
    modelClock();
    @(negedge clk);
    chk(tag, {2'b00, hiOn, loOn, statusN, sleepOut}, expVec());
  endtask

  task automatic steps(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected=done", vecCnt);
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    chk("R11", {2'b00, hiOn, loOn, statusN, sleepOut}, 8'b0000_0011);
    rstN = 1'b1;

    // sleep
    polIn = 2'b01;
    steps(3, "R3");
    chk("R3", {6'b0, sleepOut, statusN}, 8'b11);

    // forward, reverse, freewheels
    enIn = 1;
    steps(6, "R1");
    chk("R1", {4'b0, hiOn, loOn}, 8'b0110);
    polIn = 2'b10;
    step("R9");
    chk("R9", {4'b0, hiOn, loOn}, 8'b0000);
    steps(5, "R1");
    chk("R1", {4'b0, hiOn, loOn}, 8'b1001);
    polIn = 2'b00; steps(6, "R1");
    chk("R1", {4'b0, hiOn, loOn}, 8'b0011);
    polIn = 2'b11; steps(6, "R1");
    chk("R1", {4'b0, hiOn, loOn}, 8'b1100);

    // disable
    disIn = 1; steps(2, "R2");
    chk("R2", {3'b0, hiOn, loOn, statusN}, 8'b0);
    disIn = 0; steps(6, "R1");

    // current limit
    climReq = 1; steps(2, "R10");
    chk("R10", {3'b0, hiOn, loOn, statusN}, 8'b1);
    climReq = 0; steps(6, "R10");

    // undervoltage
    uvFault = 1; steps(2, "R7");
    chk("R7", {7'b0, statusN}, 8'b0);
    uvFault = 0; step("R7");
    chk("R7", {7'b0, statusN}, 8'b1);
    steps(5, "R7");

    // short circuit latch
    scFault = 1; step("R8");
    chk("R8", {4'b0, hiOn, loOn}, 8'b0);
    scFault = 0; polIn = 2'b01; steps(3, "R4");
    polIn = 2'b10; steps(3, "R4");
    chk("R4", {3'b0, hiOn, loOn, statusN}, 8'b0);
    disIn = 1; step("R5");
    disIn = 0; step("R5");
    chk("R5", {7'b0, statusN}, 8'b1);
    steps(5, "R5");

    // overtemp: disable clear needs hysteresis
    otFault = 1; otCool = 0; step("R4");
    otFault = 0; steps(2, "R4");
    disIn = 1; step("R6");
    disIn = 0; step("R6");
    chk("R6", {7'b0, statusN}, 8'b0);
    otCool = 1; disIn = 1; step("R6");
    disIn = 0; step("R6");
    chk("R6", {7'b0, statusN}, 8'b1);
    steps(5, "R6");

    // overtemp cleared by enable edge without hysteresis
    otFault = 1; otCool = 0; step("R4");
    otFault = 0; steps(2, "R4");
    enIn = 0; step("R5");
    enIn = 1; step("R6");
    chk("R6", {7'b0, statusN}, 8'b1);
    steps(5, "R5");

    // fault seen while asleep is not latched
    enIn = 0; scFault = 1; steps(2, "R3");
    chk("R3", {7'b0, statusN}, 8'b1);
    scFault = 0; step("R3");
    enIn = 1; steps(6, "R3");

    // randomised
    for (int n = 0; n < 600; n++) begin
      enIn    = ($urandom % 16) != 0;
      disIn   = ($urandom % 10) == 0;
      uvFault = ($urandom % 25) == 0;
      otFault = ($urandom % 40) == 0;
      otCool  = $urandom % 2;
      scFault = ($urandom % 40) == 0;
      climReq = ($urandom % 12) == 0;
      if (($urandom % 4) == 0) polIn = 2'($urandom);
      step("RND");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule